// File: doc/BRIEF.md
# NAND Strobe Timing Cycle Calculator

This block turns three flash-bus timing needs, given in nanoseconds, into counts of controller clock cycles: the address/command setup time, the active width of the write strobe, and the hold time after the strobe. A request carries the three nanosecond values, the controller clock rate in kHz, a variant select and a use-defaults flag. The block works through the fields in a fixed order: setup, then active width, then hold. For each field it runs one iterative divide to get the cycle count. It then runs a second divide that converts the count back to nanoseconds, for status readback.

A single restoring divider is shared by all six divisions. A request enters on a valid/ready handshake. `in_ready` is high only while the block is idle. While a request is in progress, `in_valid` is ignored, which is the block's only form of back-pressure. The result side gives no back-pressure. `out_valid` pulses for one cycle, and the result outputs keep their values until the next pulse. If any count exceeds its field limit, the pulse comes with `err` set and every result output at zero.

Top module: `nand_tcalc`

## Requirements
- R1: For each field, the count is floor(ns × clk_khz / 1,000,000) + 1, with integer arithmetic at full width.
- R2: A count can never be below 1. For example, a zero clock rate or zero nanoseconds gives a count of 1.
- R3: The setup limit is 4 when `ext_variant`=0 and 8 when `ext_variant`=1. The active-width and hold limits are both 8. A count above its limit ends the request. The block then sets `err`=1 and drives all counts, `cfg_word` and back-converted values to 0. No later field is processed.
- R4: With `use_dflt`=1 the nanosecond inputs are not used, and each count equals its field limit.
- R5: `cfg_word` holds each count minus one. Bits [2:0] carry setup, bits [5:3] carry active width, and bits [8:6] carry hold. All bits are 0 after reset and on error.
- R6: On success, each back-converted value is floor(count × 1,000,000 / clk_khz). It saturates to all ones (0xFFFFFF), which is also the value when clk_khz is 0.
- R7: `in_ready` is high only when the block is idle. A request is taken at a clock edge where `in_valid` and `in_ready` are both high. `in_valid` has no effect while the block is busy.
- R8: `out_valid` is high for exactly one cycle, 38·k cycles after the accepting edge. Here k is 6 for a full success, 3 with defaults, and 2f+1 when field f fails (setup is f=0, active width f=1, hold f=2). Results change only at that pulse and are held afterwards.
- R9: After reset, `in_ready`=1, `out_valid`=0, `err`=0, and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Idle, request can be taken |
| ns_setup | input | 16 | Setup time in ns |
| ns_act | input | 16 | Strobe active width in ns |
| ns_hold | input | 16 | Strobe hold time in ns |
| clk_khz | input | 20 | Clock rate in kHz |
| ext_variant | input | 1 | 1 raises the setup limit to 8 |
| use_dflt | input | 1 | Output limit counts without computing |
| out_valid | output | 1 | One-cycle result pulse |
| err | output | 1 | A count exceeded its limit |
| cyc_setup | output | 4 | Setup cycle count |
| cyc_act | output | 4 | Active-width cycle count |
| cyc_hold | output | 4 | Hold cycle count |
| cfg_word | output | 9 | Packed count-minus-one fields |
| bk_setup | output | 24 | Setup count back in ns |
| bk_act | output | 24 | Active-width count back in ns |
| bk_hold | output | 24 | Hold count back in ns |

## Verification
The bench targets counts that sit exactly on a limit (8 passes, 9 fails) and a setup count of 5, which fails on the base variant but passes on the extended one. A design with an off-by-one limit compare, or one that ignores the variant select, misreports one of these. A failure in the hold field checks that the abort latency is right and that the earlier good fields are cleared. A sequencer that carried on past the failure, or that kept stale counts, would show a late pulse or nonzero outputs. A zero clock rate exercises the count floor of 1 and the back-conversion saturation; a divider that fails to saturate on a zero divisor would return wrapped values. New requests offered while the block is busy check that no second calculation starts and that the latched inputs are not overwritten.

// File: rtl/nand_tcalc_pkg.sv
package nand_tcalc_pkg;
  localparam int NF    = 3;
  localparam int SCALE = 1_000_000;
  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_DIV, ST_POST, ST_FIN} tc_state_e;
endpackage

// File: rtl/nand_tcalc_div.sv
module nand_tcalc_div #(
  parameter int NUM_W = 36,
  parameter int DEN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             last,
  output logic [NUM_W-1:0] quo
);
  localparam int CW = $clog2(NUM_W);

  logic [DEN_W-1:0] rem;
  logic [NUM_W-1:0] q;
  logic [DEN_W-1:0] d;
  logic [CW-1:0]    cnt;
  logic             run;
  logic [DEN_W:0]   trial;
  logic [DEN_W-1:0] sub;
  logic             ge;

  assign trial = {rem, q[NUM_W-1]};
  assign ge    = trial >= {1'b0, d};
  assign sub   = DEN_W'(trial - {1'b0, d});
  assign last  = run && (cnt == '0);
  assign quo   = q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
      q   <= '0;
      d   <= '0;
      cnt <= '0;
      run <= 1'b0;
    end else if (ld) begin
      rem <= '0;
      q   <= num;
      d   <= den;
      cnt <= CW'(NUM_W - 1);
      run <= 1'b1;
    end else if (run) begin
      rem <= ge ? sub : trial[DEN_W-1:0];
      q   <= {q[NUM_W-2:0], ge};
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/nand_tcalc_fit.sv
module nand_tcalc_fit #(
  parameter int NUM_W = 36,
  parameter int CNT_W = 4
) (
  input  logic [NUM_W-1:0] q,
  input  logic [CNT_W-1:0] lim,
  output logic [CNT_W-1:0] cnt,
  output logic             over
);
  logic [NUM_W:0] inc;

  always_comb begin
    inc = {1'b0, q} + 1'b1;
    if (inc == '0) inc = (NUM_W+1)'(1);
    over = inc > (NUM_W+1)'(lim);
    cnt  = inc[CNT_W-1:0];
  end
endmodule

// File: rtl/nand_tcalc.sv
module nand_tcalc
  import nand_tcalc_pkg::*;
#(
  parameter int NS_W     = 16,
  parameter int KHZ_W    = 20,
  parameter int CNT_W    = 4,
  parameter int BK_W     = 24,
  parameter int LIM_BASE = 4,
  parameter int LIM_EXT  = 8,
  parameter int LIM_STRB = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [NS_W-1:0]          ns_setup,
  input  logic [NS_W-1:0]          ns_act,
  input  logic [NS_W-1:0]          ns_hold,
  input  logic [KHZ_W-1:0]         clk_khz,
  input  logic                     ext_variant,
  input  logic                     use_dflt,
  output logic                     out_valid,
  output logic                     err,
  output logic [CNT_W-1:0]         cyc_setup,
  output logic [CNT_W-1:0]         cyc_act,
  output logic [CNT_W-1:0]         cyc_hold,
  output logic [3*(CNT_W-1)-1:0]   cfg_word,
  output logic [BK_W-1:0]          bk_setup,
  output logic [BK_W-1:0]          bk_act,
  output logic [BK_W-1:0]          bk_hold
);
  localparam int NUM_W = NS_W + KHZ_W;
  localparam int DEN_W = KHZ_W;
  localparam int FLD_W = CNT_W - 1;

  tc_state_e        st;
  logic [1:0]       fld;
  logic             bmode, dmode, ext_l;
  logic [NS_W-1:0]  ns_l  [0:NF-1];
  logic [KHZ_W-1:0] khz_l;
  logic [CNT_W-1:0] w_cnt [0:NF-1];
  logic [BK_W-1:0]  w_bk  [0:NF-1];
  logic [CNT_W-1:0] r_cnt [0:NF-1];
  logic [BK_W-1:0]  r_bk  [0:NF-1];
  logic             r_err;

  logic [NUM_W-1:0] num, quo;
  logic [DEN_W-1:0] den;
  logic             div_last;
  logic [CNT_W-1:0] lim_cur, fit_cnt;
  logic             fit_over;
  logic [BK_W-1:0]  bk_new;

  assign num = bmode ? NUM_W'(w_cnt[fld]) * NUM_W'(SCALE)
                     : NUM_W'(ns_l[fld]) * NUM_W'(khz_l);
  assign den = bmode ? khz_l : DEN_W'(SCALE);
  assign lim_cur = (fld == 2'd0) ? (ext_l ? CNT_W'(LIM_EXT) : CNT_W'(LIM_BASE))
                                 : CNT_W'(LIM_STRB);
  assign bk_new = (|quo[NUM_W-1:BK_W]) ? '1 : quo[BK_W-1:0];

  nand_tcalc_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst(rst), .ld(st == ST_LOAD), .num(num), .den(den),
    .last(div_last), .quo(quo)
  );

  nand_tcalc_fit #(.NUM_W(NUM_W), .CNT_W(CNT_W)) u_fit (
    .q(quo), .lim(lim_cur), .cnt(fit_cnt), .over(fit_over)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      fld   <= '0;
      bmode <= 1'b0;
      dmode <= 1'b0;
      ext_l <= 1'b0;
      khz_l <= '0;
      r_err <= 1'b0;
      for (int i = 0; i < NF; i++) begin
        ns_l[i]  <= '0;
        w_cnt[i] <= '0;
        w_bk[i]  <= '0;
        r_cnt[i] <= '0;
        r_bk[i]  <= '0;
      end
    end else begin
      case (st)
        ST_IDLE: if (in_valid) begin
          ns_l[0] <= ns_setup;
          ns_l[1] <= ns_act;
          ns_l[2] <= ns_hold;
          khz_l   <= clk_khz;
          ext_l   <= ext_variant;
          fld     <= '0;
          dmode   <= use_dflt;
          bmode   <= use_dflt;
          if (use_dflt) begin
            w_cnt[0] <= ext_variant ? CNT_W'(LIM_EXT) : CNT_W'(LIM_BASE);
            w_cnt[1] <= CNT_W'(LIM_STRB);
            w_cnt[2] <= CNT_W'(LIM_STRB);
          end
          st <= ST_LOAD;
        end
        ST_LOAD: st <= ST_DIV;
        ST_DIV:  if (div_last) st <= ST_POST;
        ST_POST: begin
          if (!bmode) begin
            if (fit_over) begin
              r_err <= 1'b1;
              for (int i = 0; i < NF; i++) begin
                r_cnt[i] <= '0;
                r_bk[i]  <= '0;
              end
              st <= ST_FIN;
            end else begin
              w_cnt[fld] <= fit_cnt;
              bmode      <= 1'b1;
              st         <= ST_LOAD;
            end
          end else begin
            w_bk[fld] <= bk_new;
            if (fld == 2'(NF - 1)) begin
              r_err <= 1'b0;
              for (int i = 0; i < NF; i++) r_cnt[i] <= w_cnt[i];
              for (int i = 0; i < NF - 1; i++) r_bk[i] <= w_bk[i];
              r_bk[NF-1] <= bk_new;
              st <= ST_FIN;
            end else begin
              fld   <= fld + 1'b1;
              bmode <= dmode;
              st    <= ST_LOAD;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (st == ST_IDLE);
  assign out_valid = (st == ST_FIN);
  assign err       = r_err;
  assign cyc_setup = r_cnt[0];
  assign cyc_act   = r_cnt[1];
  assign cyc_hold  = r_cnt[2];
  assign bk_setup  = r_bk[0];
  assign bk_act    = r_bk[1];
  assign bk_hold   = r_bk[2];

  for (genvar gi = 0; gi < NF; gi++) begin : g_pack
    assign cfg_word[gi*FLD_W +: FLD_W] =
      (r_cnt[gi] == '0) ? '0 : FLD_W'(r_cnt[gi] - 1'b1);
  end
endmodule

// File: rtl/nand_tcalc_chk.sv
module nand_tcalc_chk #(
  parameter int CNT_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   err,
  input logic [CNT_W-1:0]       cyc_setup,
  input logic [CNT_W-1:0]       cyc_act,
  input logic [CNT_W-1:0]       cyc_hold,
  input logic [3*(CNT_W-1)-1:0] cfg_word
);
  // R7
  busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R3
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && err) |-> (cyc_setup == '0 && cyc_act == '0 && cyc_hold == '0 && cfg_word == '0));

  // R2
  min_one_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !err) |-> (cyc_setup != '0 && cyc_act != '0 && cyc_hold != '0));

  // R5
  cfg_pack_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !err) |-> (cfg_word == {3'(cyc_hold - 1'b1), 3'(cyc_act - 1'b1), 3'(cyc_setup - 1'b1)}));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_word) |-> out_valid);
endmodule

bind nand_tcalc nand_tcalc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .err(err), .cyc_setup(cyc_setup),
  .cyc_act(cyc_act), .cyc_hold(cyc_hold), .cfg_word(cfg_word)
);

// File: tb/tb_nand_tcalc.sv
`timescale 1ns/1ps
module tb_nand_tcalc;
  localparam int DIV_CYC = 16 + 20 + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [15:0] ns_setup = '0, ns_act = '0, ns_hold = '0;
  logic [19:0] clk_khz = '0;
  logic ext_variant = 1'b0, use_dflt = 1'b0;
  logic in_ready, out_valid, err;
  logic [3:0] cyc_setup, cyc_act, cyc_hold;
  logic [8:0] cfg_word;
  logic [23:0] bk_setup, bk_act, bk_hold;

  always #10 clk = ~clk;

  nand_tcalc dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .ns_setup(ns_setup), .ns_act(ns_act), .ns_hold(ns_hold),
    .clk_khz(clk_khz), .ext_variant(ext_variant), .use_dflt(use_dflt),
    .out_valid(out_valid), .err(err), .cyc_setup(cyc_setup),
    .cyc_act(cyc_act), .cyc_hold(cyc_hold), .cfg_word(cfg_word),
    .bk_setup(bk_setup), .bk_act(bk_act), .bk_hold(bk_hold)
  );

  int nchk = 0, nerr = 0;
  string scen = "R9 reset";
  bit started = 0;

  bit m_busy = 0;
  int m_since = 0, m_lat = 0;
  longint p_cyc[3], p_bk[3];
  bit p_err;
  longint e_cyc[3] = '{0, 0, 0};
  longint e_bk[3] = '{0, 0, 0};
  bit e_err = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", req, scen, $time, act, exp);
    end
  endtask

  // Behavioural reference model
  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_busy = 0;
      for (int i = 0; i < 3; i++) begin e_cyc[i] = 0; e_bk[i] = 0; end
      e_err = 0;
    end else if (m_busy) begin
      m_since++;
      if (m_since == m_lat) begin
        for (int i = 0; i < 3; i++) begin e_cyc[i] = p_cyc[i]; e_bk[i] = p_bk[i]; end
        e_err = p_err;
      end
      if (m_since == m_lat + 1) m_busy = 0;
    end else if (in_valid) begin
      longint lim[3];
      longint nsv[3];
      longint q, c;
      int k;
      lim[0] = ext_variant ? 8 : 4; lim[1] = 8; lim[2] = 8;
      nsv[0] = ns_setup; nsv[1] = ns_act; nsv[2] = ns_hold;
      p_err = 0;
      k = 0;
      if (use_dflt) begin
        for (int i = 0; i < 3; i++) p_cyc[i] = lim[i];
        k = 3;
      end else begin
        for (int i = 0; i < 3; i++) begin
          if (!p_err) begin
            q = nsv[i] * longint'(clk_khz) / 1000000;
            c = q + 1;
            if (c < 1) c = 1;
            if (c > lim[i]) begin p_err = 1; k += 1; end
            else begin p_cyc[i] = c; k += 2; end
          end
        end
      end
      for (int i = 0; i < 3; i++) begin
        if (p_err) begin p_cyc[i] = 0; p_bk[i] = 0; end
        else if (clk_khz == 0) p_bk[i] = 24'hFFFFFF;
        else begin
          p_bk[i] = p_cyc[i] * 1000000 / longint'(clk_khz);
          if (p_bk[i] > 24'hFFFFFF) p_bk[i] = 24'hFFFFFF;
        end
      end
      m_lat = DIV_CYC * k;
      m_since = 0;
      m_busy = 1;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk(in_ready == !m_busy, "R7 in_ready", in_ready, !m_busy);
      chk(out_valid == (m_busy && m_since == m_lat), "R8 out_valid", out_valid, m_busy && m_since == m_lat);
      chk(err == e_err, "R3 err", err, e_err);
      chk(cyc_setup == e_cyc[0], "R1 cyc_setup", cyc_setup, e_cyc[0]);
      chk(cyc_act == e_cyc[1], "R1 cyc_act", cyc_act, e_cyc[1]);
      chk(cyc_hold == e_cyc[2], "R1 cyc_hold", cyc_hold, e_cyc[2]);
      chk(cfg_word == 9'((e_cyc[0] == 0 ? 0 : e_cyc[0] - 1) | ((e_cyc[1] == 0 ? 0 : e_cyc[1] - 1) << 3)
                         | ((e_cyc[2] == 0 ? 0 : e_cyc[2] - 1) << 6)), "R5 cfg_word", cfg_word, e_cyc[0]);
      chk(bk_setup == e_bk[0], "R6 bk_setup", bk_setup, e_bk[0]);
      chk(bk_act == e_bk[1], "R6 bk_act", bk_act, e_bk[1]);
      chk(bk_hold == e_bk[2], "R6 bk_hold", bk_hold, e_bk[2]);
    end
  end

  task automatic run(input int s, input int a, input int h, input int khz,
                     input bit ext, input bit dflt, input bit noise, input string tag);
    @(negedge clk);
    scen = tag;
    ns_setup = 16'(s); ns_act = 16'(a); ns_hold = 16'(h);
    clk_khz = 20'(khz); ext_variant = ext; use_dflt = dflt;
    in_valid = 1'b1;
    @(negedge clk);
    if (noise) begin
      ns_setup = 16'd9999; ns_act = 16'd1; ns_hold = 16'd2;
      clk_khz = 20'd77777; use_dflt = ~dflt; ext_variant = ~ext;
    end else in_valid = 1'b0;
    while (m_busy) @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    run(20, 40, 20, 100000, 0, 0, 0, "R1 typical 100MHz");
    run(12, 25, 5, 133000, 0, 0, 0, "R1 truncation 133MHz");
    run(100, 100, 100, 0, 0, 0, 0, "R2 R6 zero clock");
    run(0, 0, 0, 500000, 1, 0, 0, "R2 zero ns");
    run(40, 10, 10, 100000, 0, 0, 0, "R3 setup over base");
    run(40, 10, 10, 100000, 1, 0, 0, "R3 setup ok ext");
    run(10, 70, 80, 100000, 1, 0, 0, "R3 hold over, act at limit");
    run(10, 90, 10, 100000, 0, 0, 0, "R3 act over");
    run(65535, 65535, 65535, 1048575, 1, 0, 0, "R3 wide operands");
    run(65535, 65535, 65535, 1048575, 0, 1, 0, "R4 defaults base");
    run(65535, 0, 0, 0, 1, 1, 0, "R4 defaults ext zero clock");
    run(30, 30, 30, 200000, 0, 0, 1, "R7 start ignored while busy");
    run(70, 70, 70, 100000, 1, 0, 0, "R8 back to back limit");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #(20 * 100000);
    nerr++;
    $display("FAIL R8 watchdog expired [%s] actual=%0d expected=%0d", scen, 1, 0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule